// File: doc/BRIEF.md
# Dual-Thread Multi-Ported Register File

A synchronous general register file for a two-thread datapath. Every register exists twice, once per hardware thread. A registered thread selector marks one copy as active. All read ports and the eight active write ports work on that copy. Two further write ports fill the other thread's copy during the same cycle, so a parked thread can be loaded while the running one computes.

A kernel-mode input swaps a window of sixteen logical registers (addresses 16 to 31) for a separate bank of sixteen kernel registers. Each stored entry is a 64-bit word with one parity bit. Reads are combinational from the state held before the clock edge, so a same-cycle read of a register being written returns the old value. A build-time option instead forwards the active write data to the reader. A change of the thread selector takes effect at the next edge, and that edge commits no writes.

Top module: `dtrf_regfile`

## Requirements
- R1: Every read port returns the active thread's copy of the addressed entry. The active thread is the value of `thread_i` registered at the previous clock edge.
- R2: Each stored entry is 65 bits. Bit 64 is the XOR of data bits 63:0, and read ports return all 65 bits.
- R3: With `kmode_i`=1, logical addresses 16 to 31 select kernel registers 0 to 15, which are separate from general registers 16 to 31. Addresses 15 and 32 still select general registers. With `kmode_i`=0, every address selects a general register.
- R4: An enabled active write port stores its data, at the next edge, into the active thread's copy. An enabled inactive write port stores into the other thread's copy. Both kinds commit in the same cycle without affecting each other.
- R5: When two write ports of the same kind target one entry in a cycle, the higher-numbered port's data is stored.
- R6: With `BYPASS`=0, a read of an entry that is written in the same cycle returns the value held before that write.
- R7: With `BYPASS`=1, a read of an entry that an active write port targets in the same cycle returns {parity, data} of the highest-numbered such port. Inactive writes are never forwarded.
- R8: In a cycle where `thread_i` differs from the active thread, no write of either kind is stored and nothing is forwarded. The new thread is active from the next edge.
- R9: After reset, every entry in both copies reads as zero and thread 0 is active.
- R10: The twelve read ports address the file independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_i | input | 1 | Requested active thread |
| kmode_i | input | 1 | Kernel window select, applies to all ports |
| rd_addr_i | input | 12x7 | Logical read addresses |
| rd_data_o | output | 12x65 | Read entries {parity, data} |
| wa_en_i | input | 8 | Active write port enables |
| wa_addr_i | input | 8x7 | Active write logical addresses |
| wa_data_i | input | 8x64 | Active write data |
| wi_en_i | input | 2 | Inactive write port enables |
| wi_addr_i | input | 2x7 | Inactive write logical addresses |
| wi_data_i | input | 2x64 | Inactive write data |

## Verification
The bench builds two instances that share all inputs and keep the default sizes. One has `BYPASS`=0 and the other `BYPASS`=1. Because the inputs are shared, a single same-cycle read-of-write stimulus shows the old value on one instance and the forwarded value on the other, and every other scenario must match on both. The full port counts and the 144-entry depth let the bench reach the real kernel window boundaries, multi-port priority at eight and two ports, and the thread-switch cycle against both write kinds.

// File: rtl/dtrf_pkg.sv
package dtrf_pkg;
  localparam int unsigned DEF_NUM_GR    = 128;
  localparam int unsigned DEF_NUM_KR    = 16;
  localparam int unsigned DEF_KWIN_BASE = 16;
  localparam int unsigned DEF_DATA_W    = 64;
  localparam int unsigned DEF_N_RD      = 12;
  localparam int unsigned DEF_N_WA      = 8;
  localparam int unsigned DEF_N_WI      = 2;
endpackage

// File: rtl/dtrf_parity_gen.sv
module dtrf_parity_gen #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W:0]   ent_o
);
  assign ent_o = {^data_i, data_i};
endmodule

// File: rtl/dtrf_addr_map.sv
module dtrf_addr_map #(
  parameter int unsigned LA_W      = 7,
  parameter int unsigned PA_W      = 8,
  parameter int unsigned NUM_GR    = 128,
  parameter int unsigned NUM_KR    = 16,
  parameter int unsigned KWIN_BASE = 16
) (
  input  logic [LA_W-1:0] laddr_i,
  input  logic            kmode_i,
  output logic [PA_W-1:0] paddr_o
);
  localparam logic [LA_W:0] WIN_LO = (LA_W+1)'(KWIN_BASE);
  localparam logic [LA_W:0] WIN_HI = (LA_W+1)'(KWIN_BASE + NUM_KR);
  localparam logic [PA_W-1:0] KR_BASE = PA_W'(NUM_GR);

  logic [LA_W:0] la_ext;
  logic          in_win;

  assign la_ext = {1'b0, laddr_i};
  assign in_win = (la_ext >= WIN_LO) && (la_ext < WIN_HI);

  // kernel bank sits above the general registers in physical space
  always_comb begin
    if (kmode_i && in_win) paddr_o = KR_BASE + PA_W'(la_ext - WIN_LO);
    else                   paddr_o = PA_W'(laddr_i);
  end
endmodule

// File: rtl/dtrf_rd_port.sv
module dtrf_rd_port #(
  parameter int unsigned N_ENT   = 144,
  parameter int unsigned PA_W    = 8,
  parameter int unsigned ENTRY_W = 65,
  parameter int unsigned N_WA    = 8,
  parameter bit          BYPASS  = 1'b0
) (
  input  logic [PA_W-1:0]                rd_pa_i,
  input  logic [N_ENT-1:0][ENTRY_W-1:0]  bank_i,
  input  logic [N_WA-1:0]                wr_en_i,
  input  logic [N_WA-1:0][PA_W-1:0]      wr_pa_i,
  input  logic [N_WA-1:0][ENTRY_W-1:0]   wr_ent_i,
  output logic [ENTRY_W-1:0]             rd_ent_o
);
  logic [ENTRY_W-1:0] stored;
  logic [ENTRY_W-1:0] fwd_ent;
  logic               fwd_hit;

  assign stored = bank_i[rd_pa_i];

  // ascending scan: last match is the highest-numbered port
  always_comb begin
    fwd_hit = 1'b0;
    fwd_ent = '0;
    for (int w = 0; w < int'(N_WA); w++) begin
      if (wr_en_i[w] && (wr_pa_i[w] == rd_pa_i)) begin
        fwd_hit = 1'b1;
        fwd_ent = wr_ent_i[w];
      end
    end
  end

  assign rd_ent_o = (BYPASS && fwd_hit) ? fwd_ent : stored;
endmodule

// File: rtl/dtrf_regfile.sv
module dtrf_regfile
  import dtrf_pkg::*;
#(
  parameter int unsigned NUM_GR    = DEF_NUM_GR,
  parameter int unsigned NUM_KR    = DEF_NUM_KR,
  parameter int unsigned KWIN_BASE = DEF_KWIN_BASE,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned N_RD      = DEF_N_RD,
  parameter int unsigned N_WA      = DEF_N_WA,
  parameter int unsigned N_WI      = DEF_N_WI,
  parameter bit          BYPASS    = 1'b0,
  localparam int unsigned LA_W     = $clog2(NUM_GR),
  localparam int unsigned N_ENT    = NUM_GR + NUM_KR,
  localparam int unsigned PA_W     = $clog2(N_ENT),
  localparam int unsigned ENTRY_W  = DATA_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          thread_i,
  input  logic                          kmode_i,
  input  logic [N_RD-1:0][LA_W-1:0]     rd_addr_i,
  output logic [N_RD-1:0][ENTRY_W-1:0]  rd_data_o,
  input  logic [N_WA-1:0]               wa_en_i,
  input  logic [N_WA-1:0][LA_W-1:0]     wa_addr_i,
  input  logic [N_WA-1:0][DATA_W-1:0]   wa_data_i,
  input  logic [N_WI-1:0]               wi_en_i,
  input  logic [N_WI-1:0][LA_W-1:0]     wi_addr_i,
  input  logic [N_WI-1:0][DATA_W-1:0]   wi_data_i
);
  logic [N_ENT-1:0][ENTRY_W-1:0] mem_q [2];
  logic [N_ENT-1:0][ENTRY_W-1:0] act_bank;
  logic                          thr_q;
  logic                          thr_n;
  logic                          commit;

  logic [N_WA-1:0][PA_W-1:0]     wa_pa;
  logic [N_WA-1:0][ENTRY_W-1:0]  wa_ent;
  logic [N_WA-1:0]               wa_live;
  logic [N_WI-1:0][PA_W-1:0]     wi_pa;
  logic [N_WI-1:0][ENTRY_W-1:0]  wi_ent;
  logic [N_RD-1:0][PA_W-1:0]     rd_pa;

  assign thr_n    = ~thr_q;
  assign commit   = (thread_i == thr_q);
  assign act_bank = mem_q[thr_q];
  assign wa_live  = commit ? wa_en_i : '0;

  for (genvar w = 0; w < int'(N_WA); w++) begin : g_wa
    dtrf_addr_map #(
      .LA_W(LA_W), .PA_W(PA_W), .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KWIN_BASE(KWIN_BASE)
    ) u_map (
      .laddr_i(wa_addr_i[w]), .kmode_i(kmode_i), .paddr_o(wa_pa[w])
    );
    dtrf_parity_gen #(.DATA_W(DATA_W)) u_par (
      .data_i(wa_data_i[w]), .ent_o(wa_ent[w])
    );
  end

  for (genvar w = 0; w < int'(N_WI); w++) begin : g_wi
    dtrf_addr_map #(
      .LA_W(LA_W), .PA_W(PA_W), .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KWIN_BASE(KWIN_BASE)
    ) u_map (
      .laddr_i(wi_addr_i[w]), .kmode_i(kmode_i), .paddr_o(wi_pa[w])
    );
    dtrf_parity_gen #(.DATA_W(DATA_W)) u_par (
      .data_i(wi_data_i[w]), .ent_o(wi_ent[w])
    );
  end

  for (genvar r = 0; r < int'(N_RD); r++) begin : g_rd
    dtrf_addr_map #(
      .LA_W(LA_W), .PA_W(PA_W), .NUM_GR(NUM_GR), .NUM_KR(NUM_KR), .KWIN_BASE(KWIN_BASE)
    ) u_map (
      .laddr_i(rd_addr_i[r]), .kmode_i(kmode_i), .paddr_o(rd_pa[r])
    );
    dtrf_rd_port #(
      .N_ENT(N_ENT), .PA_W(PA_W), .ENTRY_W(ENTRY_W), .N_WA(N_WA), .BYPASS(BYPASS)
    ) u_port (
      .rd_pa_i(rd_pa[r]), .bank_i(act_bank), .wr_en_i(wa_live),
      .wr_pa_i(wa_pa), .wr_ent_i(wa_ent), .rd_ent_o(rd_data_o[r])
    );

    AST_RD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[r][DATA_W] == ^rd_data_o[r][DATA_W-1:0]); // R2
  end

  // later loop iterations override earlier ones: higher port wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q[0] <= '0;
      mem_q[1] <= '0;
      thr_q    <= 1'b0;
    end else begin
      thr_q <= thread_i;
      if (commit) begin
        for (int w = 0; w < int'(N_WA); w++)
          if (wa_en_i[w]) mem_q[thr_q][wa_pa[w]] <= wa_ent[w];
        for (int w = 0; w < int'(N_WI); w++)
          if (wi_en_i[w]) mem_q[thr_n][wi_pa[w]] <= wi_ent[w];
      end
    end
  end

  AST_KWIN_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kmode_i && (int'(rd_addr_i[0]) >= int'(KWIN_BASE))
             && (int'(rd_addr_i[0]) < int'(KWIN_BASE + NUM_KR)))
    |-> (int'(rd_pa[0]) >= int'(NUM_GR))); // R3

  AST_GR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kmode_i |-> (int'(rd_pa[0]) < int'(NUM_GR))); // R3

  if (BYPASS) begin : g_ast_byp
    AST_BYP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && wa_en_i[N_WA-1] && (wa_addr_i[N_WA-1] == rd_addr_i[0]))
      |-> (rd_data_o[0] == {^wa_data_i[N_WA-1], wa_data_i[N_WA-1]})); // R7
  end else begin : g_ast_nobyp
    AST_WR_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(commit && wa_en_i[N_WA-1])
        && (rd_addr_i[0] == $past(wa_addr_i[N_WA-1]))
        && (kmode_i == $past(kmode_i)))
      |-> (rd_data_o[0][DATA_W-1:0] == $past(wa_data_i[N_WA-1]))); // R4
  end
endmodule

// File: tb/dtrf_regfile_bench.sv
module dtrf_regfile_bench;
  localparam int CLK_P = 10;
  localparam int LA_W  = 7;
  localparam int DW    = 64;
  localparam int EW    = 65;
  localparam int NRD   = 12;
  localparam int NWA   = 8;
  localparam int NWI   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic thread_i, kmode_i;
  logic [NRD-1:0][LA_W-1:0] rd_addr;
  logic [NRD-1:0][EW-1:0]   rd_a, rd_b;
  logic [NWA-1:0]           wa_en;
  logic [NWA-1:0][LA_W-1:0] wa_addr;
  logic [NWA-1:0][DW-1:0]   wa_data;
  logic [NWI-1:0]           wi_en;
  logic [NWI-1:0][LA_W-1:0] wi_addr;
  logic [NWI-1:0][DW-1:0]   wi_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dtrf_regfile #(.BYPASS(1'b0)) u_dtrf_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .thread_i(thread_i), .kmode_i(kmode_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_a),
    .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
    .wi_en_i(wi_en), .wi_addr_i(wi_addr), .wi_data_i(wi_data)
  );

  dtrf_regfile #(.BYPASS(1'b1)) u_dtrf_regfile_byp (
    .clk_i(clk), .rst_ni(rst_ni), .thread_i(thread_i), .kmode_i(kmode_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_b),
    .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
    .wi_en_i(wi_en), .wi_addr_i(wi_addr), .wi_data_i(wi_data)
  );

  function automatic logic [EW-1:0] ent(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    return 64'h0123_4567_89AB_CDEF ^ (64'(k + 1) << (k * 5));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // both instances must agree with exp
  task automatic chk2(input string req, input string what, input int p,
                      input logic [EW-1:0] exp);
    chk(req, {what, " nobyp"}, rd_a[p], exp);
    chk(req, {what, " byp"},   rd_b[p], exp);
  endtask

  task automatic idle();
    wa_en = '0;
    wi_en = '0;
  endtask

  // commit current cycle, land at next negedge with writes cleared
  task automatic next_cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    for (int r = 0; r < NRD; r++) rd_addr[r] = LA_W'(r * 10 + 3);
    #1;
    for (int r = 0; r < NRD; r++) chk2("R9", "reset read", r, '0);
  endtask

  task automatic t_basic();
    for (int w = 0; w < NWA; w++) begin
      wa_en[w] = 1'b1;
      wa_addr[w] = LA_W'(70 + w);
      wa_data[w] = pat(w);
    end
    next_cyc();
    for (int r = 0; r < NRD; r++) rd_addr[r] = LA_W'(70 + (r % NWA));
    #1;
    for (int r = 0; r < NRD; r++) chk2("R10", "all ports write+read", r, ent(pat(r % NWA)));
    chk("R2", "parity odd data", rd_a[0], ent(pat(0)));
  endtask

  task automatic t_priority();
    wa_en[2] = 1'b1; wa_addr[2] = 7'd40; wa_data[2] = 64'h2222_0000_0000_0002;
    wa_en[6] = 1'b1; wa_addr[6] = 7'd40; wa_data[6] = 64'h6666_0000_0000_0007;
    wi_en[0] = 1'b1; wi_addr[0] = 7'd40; wi_data[0] = 64'hAAAA_0000_0000_0000;
    wi_en[1] = 1'b1; wi_addr[1] = 7'd40; wi_data[1] = 64'hBBBB_0000_0000_0001;
    next_cyc();
    rd_addr[0] = 7'd40;
    #1;
    chk2("R5", "active higher port wins", 0, ent(64'h6666_0000_0000_0007));
  endtask

  task automatic t_raw();
    wa_en[0] = 1'b1; wa_addr[0] = 7'd50; wa_data[0] = 64'hD1D1_D1D1_0000_0001;
    next_cyc();
    wa_en[1] = 1'b1; wa_addr[1] = 7'd50; wa_data[1] = 64'hD2D2_D2D2_0000_0002;
    wa_en[3] = 1'b1; wa_addr[3] = 7'd50; wa_data[3] = 64'hD3D3_D3D3_0000_0003;
    wi_en[0] = 1'b1; wi_addr[0] = 7'd50; wi_data[0] = 64'hEEEE_0000_0000_0050;
    rd_addr[5] = 7'd50;
    rd_addr[6] = 7'd51;
    #1;
    chk("R6", "same-cycle read old", rd_a[5], ent(64'hD1D1_D1D1_0000_0001));
    chk("R7", "bypass highest port", rd_b[5], ent(64'hD3D3_D3D3_0000_0003));
    chk("R7", "no bypass other addr", rd_b[6], '0);
    next_cyc();
    #1;
    chk2("R5", "stored after raw", 5, ent(64'hD3D3_D3D3_0000_0003));
    wi_en[0] = 1'b1; wi_addr[0] = 7'd52; wi_data[0] = 64'h5252_0000_0000_0052;
    rd_addr[7] = 7'd52;
    #1;
    chk("R7", "inactive write not forwarded", rd_b[7], '0);
    next_cyc();
  endtask

  task automatic t_kernel();
    kmode_i = 1'b0;
    wa_en[0] = 1'b1; wa_addr[0] = 7'd20; wa_data[0] = 64'hA020;
    wa_en[1] = 1'b1; wa_addr[1] = 7'd15; wa_data[1] = 64'hB015;
    wa_en[2] = 1'b1; wa_addr[2] = 7'd32; wa_data[2] = 64'hC032;
    wa_en[3] = 1'b1; wa_addr[3] = 7'd31; wa_data[3] = 64'hE031;
    next_cyc();
    kmode_i = 1'b1;
    wa_en[0] = 1'b1; wa_addr[0] = 7'd20; wa_data[0] = 64'hF120;
    wa_en[1] = 1'b1; wa_addr[1] = 7'd16; wa_data[1] = 64'hF116;
    next_cyc();
    rd_addr[0] = 7'd20; rd_addr[1] = 7'd15; rd_addr[2] = 7'd32;
    rd_addr[3] = 7'd31; rd_addr[4] = 7'd16;
    #1;
    chk2("R3", "kernel 20", 0, ent(64'hF120));
    chk2("R3", "below window", 1, ent(64'hB015));
    chk2("R3", "above window", 2, ent(64'hC032));
    chk2("R3", "kernel 31 untouched", 3, '0);
    chk2("R3", "kernel 16", 4, ent(64'hF116));
    kmode_i = 1'b0;
    #1;
    chk2("R3", "general 20", 0, ent(64'hA020));
    chk2("R3", "general 31", 3, ent(64'hE031));
    chk2("R3", "general 16", 4, '0);
  endtask

  task automatic t_switch();
    thread_i = 1'b1;
    wa_en[0] = 1'b1; wa_addr[0] = 7'd60; wa_data[0] = 64'h6060;
    wi_en[0] = 1'b1; wi_addr[0] = 7'd61; wi_data[0] = 64'h6161;
    rd_addr[0] = 7'd60;
    #1;
    chk2("R8", "no forward on switch", 0, '0);
    next_cyc();
    rd_addr[0] = 7'd60; rd_addr[1] = 7'd61; rd_addr[2] = 7'd40;
    rd_addr[3] = 7'd50; rd_addr[4] = 7'd52; rd_addr[5] = 7'd70;
    #1;
    chk2("R8", "active write dropped", 0, '0);
    chk2("R8", "inactive write dropped", 1, '0);
    chk2("R5", "inactive higher port wins", 2, ent(64'hBBBB_0000_0000_0001));
    chk2("R4", "inactive write same cycle", 3, ent(64'hEEEE_0000_0000_0050));
    chk2("R4", "inactive write alone", 4, ent(64'h5252_0000_0000_0052));
    chk2("R1", "thread1 copy empty", 5, '0);
    wa_en[0] = 1'b1; wa_addr[0] = 7'd62; wa_data[0] = 64'h1062;
    wi_en[0] = 1'b1; wi_addr[0] = 7'd62; wi_data[0] = 64'h0062;
    next_cyc();
    thread_i = 1'b0;
    rd_addr[0] = 7'd62;
    #1;
    chk2("R1", "old thread until edge", 0, ent(64'h1062));
    next_cyc();
    rd_addr[0] = 7'd62; rd_addr[1] = 7'd60; rd_addr[2] = 7'd70; rd_addr[3] = 7'd40;
    #1;
    chk2("R1", "thread0 copy", 0, ent(64'h0062));
    chk2("R8", "dropped write absent", 1, '0);
    chk2("R1", "thread0 kept", 2, ent(pat(0)));
    chk2("R4", "active kept", 3, ent(64'h6666_0000_0000_0007));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    thread_i = 1'b0;
    kmode_i  = 1'b0;
    rd_addr  = '0;
    wa_addr  = '0;
    wa_data  = '0;
    wi_addr  = '0;
    wi_data  = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    next_cyc();
    t_priority();
    next_cyc();
    t_raw();
    t_kernel();
    next_cyc();
    t_switch();
    next_cyc();
    finish_run();
  end
endmodule